// File: doc/BRIEF.md
# PCI Initiator Burst Sequencer

This block runs the initiator side of a 32-bit PCI burst on behalf of one on-chip port unit. An internal client hands it a request (start address, bus command, word count). The block raises its bus request and waits for the grant. It then drives one address phase with the frame signal asserted and moves the data phases with the initiator-ready signal. While it does so it watches device-select, target-ready and stop from the target. Write words are pulled from a streaming source one at a time. Read words are delivered on a streaming output. When the request ends, a single status pulse reports how it ended and how many words moved.

The sequencer is a five-state machine. **IDLE** accepts a request of non-zero length and goes to **REQ**. **REQ** holds the bus request until the grant is sampled and then goes to **ADDR**. **ADDR** is one cycle with address and command on the bus and always goes to **DATA**. **DATA** leaves for **TURN** on any of these events: completion of the final phase, a disconnect with data, a retry, a target abort, or a device-select timeout. Otherwise it stays in **DATA** for further phases and wait states. **TURN** is one turnaround cycle with the control lines driven inactive. From there the block goes back to **REQ** if a disconnect left words to move, and to **IDLE** otherwise. The status pulse is given in **TURN** only on the way to **IDLE**.

Both the disconnect-with-data resume and the device-select timeout are handled inside the block. The client sees one status per request. A retry is handed back to the client as a pending status. Bus lines are split into output value, output enable and input value. Tri-state pads belong to the chip level.

Top module: `pci_master_seq`

## Requirements
- R1: A request is taken only in IDLE (`req_ready` high). A request with `req_len` of zero is ignored: no bus request is raised, no status is given and the block stays ready.
- R2: After taking a request, `pci_req_n` is low until `pci_gnt_n` is sampled low. The address phase follows in the next cycle, with `pci_frame_n` low, `pci_irdy_n` high, `pci_ad_o` equal to the current address and `pci_cbe_n` equal to the command.
- R3: During data phases `pci_irdy_n` is low. `pci_frame_n` stays low while more than one word remains and is high during the phase that carries the last word. Once it is high within a tenure, it stays high.
- R4: A data phase completes only on a clock where `pci_devsel_n` and `pci_trdy_n` are both low. Any other clock without stop is a wait state, and the write word on `pci_ad_o` is held.
- R5: If `pci_devsel_n` stays high for DEVSEL_LIMIT (default 5) data cycles after the address phase, the tenure ends as a master abort with status code 2'b01. A claim in the DEVSEL_LIMIT-th cycle is still accepted.
- R6: Stop with `pci_trdy_n` low and `pci_devsel_n` low completes the current word and ends the tenure (a disconnect). If words remain, the bus is requested again and the burst resumes at the start address plus 4 times the number of words already moved.
- R7: Stop with `pci_trdy_n` high and `pci_devsel_n` low moves no word and ends the request with code 2'b11 (retry pending).
- R8: Stop with `pci_devsel_n` high ends the request with code 2'b10 (target abort).
- R9: On the clock after the final completed phase, `pci_irdy_n` and `pci_frame_n` are high and `pci_ad_oe` is low. `pci_ctl_oe` stays high for that one turnaround cycle.
- R10: Each accepted request gives exactly one single-cycle `sts_valid`. `sts_code` is 2'b00 for done and `sts_count` is the number of words moved.
- R11: Every completed read phase produces one `rd_valid` pulse on the next clock, carrying the `pci_ad_i` value of that phase, in bus order.
- R12: `req_cmd` bit 0 set marks a write. Write words go out on `pci_ad_o` in the order of the source stream, and `wr_take` pops the stream head when it is loaded for a phase.
- R13: Out of reset the block is in IDLE: `req_ready` is high, `pci_req_n`, `pci_frame_n` and `pci_irdy_n` are high, and `pci_ctl_oe`, `pci_ad_oe` and `sts_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | Block can take a request (IDLE) |
| req_addr | input | 32 | Burst start address |
| req_cmd | input | 4 | Bus command; bit 0 set = write |
| req_len | input | LEN_W | Number of words to move |
| wr_data | input | 32 | Head of the write word stream |
| wr_take | output | 1 | Pops the write stream head |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word strobe |
| sts_valid | output | 1 | End-of-request status strobe |
| sts_code | output | 2 | 00 done, 01 master abort, 10 target abort, 11 retry pending |
| sts_count | output | LEN_W | Words moved for this request |
| pci_req_n | output | 1 | Bus request, active low |
| pci_gnt_n | input | 1 | Bus grant, active low |
| pci_frame_n | output | 1 | Frame value |
| pci_irdy_n | output | 1 | Initiator ready value |
| pci_ctl_oe | output | 1 | Enable for frame, initiator ready and byte-enable lines |
| pci_cbe_n | output | 4 | Command / byte enables |
| pci_ad_o | output | 32 | Address/data out value |
| pci_ad_oe | output | 1 | Address/data out enable |
| pci_ad_i | input | 32 | Address/data in value |
| pci_devsel_n | input | 1 | Device select from target |
| pci_trdy_n | input | 1 | Target ready |
| pci_stop_n | input | 1 | Stop from target |

## Verification
The hardest case to reach is the disconnect-with-data resume. The stop must come on a phase that also carries a word, not on the last word, and the second tenure must be checked for both its re-arbitration and its advanced address. The bench target model takes a per-test phase index and response kind for its one-shot stop, along with a claim delay and a wait-state count. With these it places the disconnect mid-burst, and in a separate test puts the device-select claim exactly in the last cycle the timeout allows. Every address phase is compared with the start address plus four times the words moved so far, and the number of tenures per request is counted.

// File: rtl/pcim_pkg.sv
package pcim_pkg;
    localparam int DW = 32;
    localparam int CMD_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        END_DONE   = 2'b00,
        END_MABORT = 2'b01,
        END_TABORT = 2'b10,
        END_RETRY  = 2'b11
    } end_code_e;
endpackage

// File: rtl/pcim_claim_timer.sv
module pcim_claim_timer #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic claim,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    // cnt_q holds the number of unclaimed data cycles before this one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (claim) begin
                seen_q <= 1'b1;
            end
            if (!seen_q && !claim && cnt_q < LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired = run && !seen_q && !claim && (cnt_q == LAST);

    // R5: an expiry always makes the sequencer leave the data state
    p_expire_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);
endmodule

// File: rtl/pcim_beat_track.sv
module pcim_beat_track #(
    parameter int LEN_W = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    load_addr,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    input  logic             pop,
    input  logic [DW-1:0]    pop_data,
    output logic [DW-1:0]    addr_q,
    output logic [LEN_W-1:0] remain_q,
    output logic [LEN_W-1:0] count_q,
    output logic [DW-1:0]    wdata_q
);
    localparam logic [DW-1:0] WORD_BYTES = DW'(DW / 8);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            count_q  <= '0;
            len_q    <= '0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= load_len;
            count_q  <= '0;
            len_q    <= load_len;
        end else if (step) begin
            addr_q   <= addr_q + WORD_BYTES;
            remain_q <= remain_q - 1'b1;
            count_q  <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (pop) begin
            wdata_q <= pop_data;
        end
    end

    // R10: words moved plus words left always equal the request length
    p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, remain_q} + {1'b0, count_q}) == {1'b0, len_q});

    // R10: the sequencer never completes a phase with nothing left
    p_step_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain_q != '0));
endmodule

// File: rtl/pci_master_seq.sv
module pci_master_seq
    import pcim_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic [3:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic [31:0]      wr_data,
    output logic             wr_take,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             sts_valid,
    output logic [1:0]       sts_code,
    output logic [LEN_W-1:0] sts_count,
    output logic             pci_req_n,
    input  logic             pci_gnt_n,
    output logic             pci_frame_n,
    output logic             pci_irdy_n,
    output logic             pci_ctl_oe,
    output logic [3:0]       pci_cbe_n,
    output logic [31:0]      pci_ad_o,
    output logic             pci_ad_oe,
    input  logic [31:0]      pci_ad_i,
    input  logic             pci_devsel_n,
    input  logic             pci_trdy_n,
    input  logic             pci_stop_n
);
    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);
    localparam logic [3:0]       BE_ALL   = 4'b0000;
    localparam logic [3:0]       BE_NONE  = 4'b1111;

    seq_state_e       state_q, state_d;
    end_code_e        code_q, code_d;
    logic             resume_q, resume_d;
    logic             wr_q;
    logic [CMD_W-1:0] cmd_q;
    logic             accept, step, pop, expired, in_data;
    logic             rd_valid_q;
    logic [DW-1:0]    rd_data_q;
    logic [DW-1:0]    addr_w, wdata_w;
    logic [LEN_W-1:0] remain_w, count_w;

    assign accept  = (state_q == ST_IDLE) && req_valid && (req_len != '0);
    assign in_data = (state_q == ST_DATA);

    pcim_claim_timer #(
        .LIMIT (DEVSEL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_data),
        .claim   (!pci_devsel_n),
        .expired (expired)
    );

    pcim_beat_track #(
        .LEN_W (LEN_W),
        .DW    (DW)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (step),
        .pop       (pop),
        .pop_data  (wr_data),
        .addr_q    (addr_w),
        .remain_q  (remain_w),
        .count_q   (count_w),
        .wdata_q   (wdata_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            code_q   <= END_DONE;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            code_q   <= code_d;
            resume_q <= resume_d;
        end
    end

    // request attributes and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            cmd_q      <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (accept) begin
                wr_q  <= req_cmd[0];
                cmd_q <= req_cmd;
            end
            rd_valid_q <= step && !wr_q;
            if (step && !wr_q) begin
                rd_data_q <= pci_ad_i;
            end
        end
    end

    // next state and phase decisions
    always_comb begin
        state_d  = state_q;
        code_d   = code_q;
        resume_d = resume_q;
        step     = 1'b0;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_REQ;
                    code_d   = END_DONE;
                    resume_d = 1'b0;
                end
            end
            ST_REQ: begin
                if (!pci_gnt_n) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                state_d = ST_DATA;
                pop     = wr_q;
            end
            ST_DATA: begin
                if (pci_devsel_n && !pci_stop_n) begin
                    state_d  = ST_TURN;
                    code_d   = END_TABORT;
                    resume_d = 1'b0;
                end else if (expired) begin
                    state_d  = ST_TURN;
                    code_d   = END_MABORT;
                    resume_d = 1'b0;
                end else if (!pci_devsel_n && !pci_trdy_n) begin
                    step = 1'b1;
                    if (remain_w == ONE_LEFT) begin
                        state_d  = ST_TURN;
                        code_d   = END_DONE;
                        resume_d = 1'b0;
                    end else if (!pci_stop_n) begin
                        state_d  = ST_TURN;
                        resume_d = 1'b1;
                    end else begin
                        pop = wr_q;
                    end
                end else if (!pci_devsel_n && !pci_stop_n) begin
                    state_d  = ST_TURN;
                    code_d   = END_RETRY;
                    resume_d = 1'b0;
                end
            end
            ST_TURN: begin
                state_d = resume_q ? ST_REQ : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        pci_req_n   = !(state_q == ST_REQ);
        pci_frame_n = !((state_q == ST_ADDR) || (in_data && remain_w > ONE_LEFT));
        pci_irdy_n  = !in_data;
        pci_ctl_oe  = (state_q == ST_ADDR) || in_data || (state_q == ST_TURN);
        if (state_q == ST_ADDR) begin
            pci_cbe_n = cmd_q;
        end else if (in_data) begin
            pci_cbe_n = BE_ALL;
        end else begin
            pci_cbe_n = BE_NONE;
        end
        pci_ad_oe = (state_q == ST_ADDR) || (in_data && wr_q);
        pci_ad_o  = (state_q == ST_ADDR) ? addr_w : wdata_w;
        wr_take   = pop;
        sts_valid = (state_q == ST_TURN) && !resume_q;
        sts_code  = code_q;
        sts_count = count_w;
        rd_valid  = rd_valid_q;
        rd_data   = rd_data_q;
    end

    // R1: a zero-length request leaves the block ready
    p_ignore_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_len == '0) |=> req_ready);

    // R2: the address phase is only entered after a sampled grant
    p_addr_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> $past(!pci_gnt_n));

    // R2: the request line is held until granted
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_req_n && pci_gnt_n) |=> !pci_req_n);

    // R3: frame stays released once the last phase has begun
    p_frame_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && pci_frame_n) |=> pci_frame_n);

    // R4: a wait state keeps the phase open with the same bus word
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && !pci_devsel_n && pci_trdy_n && pci_stop_n)
        |=> (!pci_irdy_n && $stable(pci_ad_o)));

    // R9: after the final phase the bus control is released
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && !pci_devsel_n && !pci_trdy_n && pci_frame_n)
        |=> (pci_irdy_n && pci_frame_n && !pci_ad_oe && pci_ctl_oe));

    // R10: status is a single-cycle pulse
    p_sts_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> !sts_valid);
endmodule

// File: tb/pci_master_seq_bench.sv
module pci_master_seq_bench;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic [3:0]       req_cmd = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [31:0]      wr_data;
    logic             wr_take;
    logic [31:0]      rd_data;
    logic             rd_valid;
    logic             sts_valid;
    logic [1:0]       sts_code;
    logic [LEN_W-1:0] sts_count;
    logic             pci_req_n;
    logic             gnt_n = 1'b1;
    logic             pci_frame_n, pci_irdy_n, pci_ctl_oe, pci_ad_oe;
    logic [3:0]       pci_cbe_n;
    logic [31:0]      pci_ad_o;
    logic [31:0]      ad_in = '0;
    logic             devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // target and arbiter model settings
    int t_dly = 0, t_wait = 0, t_stop_at = -1, t_stop_kind = 0, gnt_dly = 0;
    int dcyc = 0, phase = 0, wcnt = 0, gidx = 0, tenures = 0, gcnt = 0;
    int exp_len = 0, sts_seen = 0;
    bit exp_wr = 1'b0, prev_final = 1'b0;
    logic [31:0] exp_base = '0, wstart = '0, wptr = '0;
    logic [3:0]  exp_cmd = '0;

    int          q_code[$];
    int          q_cnt[$];
    logic [31:0] q_rd[$];

    always #5 clk = ~clk;

    pci_master_seq #(.LEN_W(LEN_W), .DEVSEL_LIMIT(5)) u_pci_master_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_len(req_len),
        .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .sts_valid(sts_valid), .sts_code(sts_code), .sts_count(sts_count),
        .pci_req_n(pci_req_n), .pci_gnt_n(gnt_n),
        .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n), .pci_ctl_oe(pci_ctl_oe),
        .pci_cbe_n(pci_cbe_n), .pci_ad_o(pci_ad_o), .pci_ad_oe(pci_ad_oe),
        .pci_ad_i(ad_in), .pci_devsel_n(devsel_n), .pci_trdy_n(trdy_n),
        .pci_stop_n(stop_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // write stream source
    assign wr_data = 32'h5000_0000 + wptr;
    always @(posedge clk) begin
        if (!rst_n) wptr <= '0;
        else if (wr_take) wptr <= wptr + 1;
    end

    // arbiter model
    always @(negedge clk) begin
        if (rst_n && !pci_req_n) begin
            gcnt++;
            gnt_n = !(gcnt > gnt_dly);
        end else begin
            gcnt = 0;
            gnt_n = 1'b1;
        end
    end

    // target model
    always @(negedge clk) begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        if (rst_n) begin
            if (prev_final) begin
                chk(pci_irdy_n && pci_frame_n && !pci_ad_oe && pci_ctl_oe, "R9",
                    "release after final phase",
                    {pci_irdy_n, pci_frame_n, pci_ad_oe, pci_ctl_oe}, 4'b1101);
            end
            prev_final = 1'b0;
            if (pci_ctl_oe && !pci_frame_n && pci_irdy_n) begin
                tenures++;
                dcyc = 0; phase = 0; wcnt = 0;
                chk(pci_ad_o == exp_base + 32'(4 * gidx), "R2 R6", "address phase",
                    pci_ad_o, exp_base + 32'(4 * gidx));
                chk(pci_cbe_n == exp_cmd, "R2", "command", pci_cbe_n, exp_cmd);
            end else if (!pci_irdy_n) begin
                dcyc++;
                if (dcyc > t_dly) begin
                    devsel_n = 1'b0;
                    if (wcnt < t_wait) begin
                        wcnt++;
                    end else begin
                        bit give;
                        give = 1'b1;
                        if (phase == t_stop_at) begin
                            t_stop_at = -1;
                            stop_n = 1'b0;
                            if (t_stop_kind == 1) give = 1'b0;
                            if (t_stop_kind == 2) begin
                                give = 1'b0;
                                devsel_n = 1'b1;
                            end
                        end
                        if (give) begin
                            trdy_n = 1'b0;
                            chk(pci_frame_n == (gidx == exp_len - 1), "R3",
                                "frame level at phase", pci_frame_n, (gidx == exp_len - 1));
                            if (exp_wr) begin
                                chk(pci_ad_oe && pci_ad_o == 32'h5000_0000 + wstart + 32'(gidx),
                                    "R4 R12", "write word", pci_ad_o,
                                    32'h5000_0000 + wstart + 32'(gidx));
                            end else begin
                                ad_in = 32'hA000_0000 + 32'(gidx);
                            end
                            prev_final = (gidx == exp_len - 1);
                            gidx++;
                            phase++;
                            wcnt = 0;
                        end
                    end
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sts_valid) begin
                sts_seen++;
                if (q_code.size() == 0) begin
                    chk(1'b0, "R10", "unexpected status", sts_code, 0);
                end else begin
                    int ec, en;
                    ec = q_code.pop_front();
                    en = q_cnt.pop_front();
                    chk(sts_code == 2'(ec), "R5 R7 R8 R10", "status code", sts_code, ec);
                    chk(sts_count == LEN_W'(en), "R10", "status count", sts_count, en);
                end
            end
            if (rd_valid) begin
                if (q_rd.size() == 0) begin
                    chk(1'b0, "R11", "unexpected read word", rd_data, 0);
                end else begin
                    logic [31:0] ew;
                    ew = q_rd.pop_front();
                    chk(rd_data == ew, "R11", "read word", rd_data, ew);
                end
            end
        end
    end

    task automatic run_req(input bit wr, input logic [31:0] a, input int len,
                           input int ecode, input int ecnt, input int eten,
                           input string tag);
        int seen0;
        @(negedge clk);
        exp_base = a; exp_len = len; exp_wr = wr; gidx = 0; tenures = 0;
        wstart = wptr;
        exp_cmd = wr ? 4'b0111 : 4'b0110;
        q_code.push_back(ecode);
        q_cnt.push_back(ecnt);
        if (!wr) begin
            for (int i = 0; i < ecnt; i++) q_rd.push_back(32'hA000_0000 + 32'(i));
        end
        seen0 = sts_seen;
        req_valid = 1'b1; req_addr = a; req_cmd = exp_cmd; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000 && sts_seen == seen0; i++) @(negedge clk);
        chk(sts_seen == seen0 + 1, tag, "one status per request", sts_seen - seen0, 1);
        chk(tenures == eten, tag, "bus tenures", tenures, eten);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(req_ready && pci_req_n && pci_frame_n && pci_irdy_n && !pci_ctl_oe
            && !pci_ad_oe && !sts_valid, "R13", "reset outputs",
            {req_ready, pci_req_n, pci_frame_n, pci_irdy_n, pci_ctl_oe, pci_ad_oe, sts_valid},
            7'b1111000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 zero length ignored
        req_valid = 1'b1; req_addr = 32'h0BAD_0000; req_cmd = 4'b0110; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk(pci_req_n && req_ready && !sts_valid, "R1", "zero length ignored",
                {pci_req_n, req_ready, sts_valid}, 3'b110);
            @(negedge clk);
        end

        // R2 R3 R11 plain read burst
        gnt_dly = 2;
        run_req(1'b0, 32'h1000_0000, 4, 0, 4, 1, "R2 R11");

        // R4 R12 write with claim delay and wait states
        gnt_dly = 0; t_dly = 2; t_wait = 2;
        run_req(1'b1, 32'h2000_0040, 3, 0, 3, 1, "R4 R12");

        // R6 disconnect with data on a read, resume
        t_dly = 0; t_wait = 0; t_stop_at = 2; t_stop_kind = 0;
        run_req(1'b0, 32'h3000_0000, 6, 0, 6, 2, "R6");

        // R6 disconnect on a write with waits
        t_wait = 1; t_stop_at = 1; t_stop_kind = 0;
        run_req(1'b1, 32'h3100_0000, 5, 0, 5, 2, "R6 R12");

        // R7 retry after two words
        t_wait = 0; t_stop_at = 2; t_stop_kind = 1;
        run_req(1'b0, 32'h4000_0000, 4, 3, 2, 1, "R7");

        // R7 retry on the first write phase
        t_stop_at = 0; t_stop_kind = 1;
        run_req(1'b1, 32'h4100_0000, 2, 3, 0, 1, "R7");

        // R5 no claim: master abort after five data cycles
        t_stop_at = -1; t_dly = 99;
        run_req(1'b0, 32'h6000_0000, 3, 1, 0, 1, "R5");
        chk(dcyc == 5, "R5", "data cycles before abort", dcyc, 5);

        // R5 claim in the last allowed cycle
        t_dly = 4;
        run_req(1'b0, 32'h6100_0000, 2, 0, 2, 1, "R5");

        // R8 target abort after one word
        t_dly = 0; t_stop_at = 1; t_stop_kind = 2;
        run_req(1'b0, 32'h7000_0000, 4, 2, 1, 1, "R8");

        // R3 single word write: frame released in the only data phase
        t_stop_at = -1;
        run_req(1'b1, 32'h8000_0000, 1, 0, 1, 1, "R3");

        repeat (4) @(negedge clk);
        chk(q_code.size() == 0 && q_rd.size() == 0, "R10 R11", "scoreboard drained",
            q_code.size() + q_rd.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule